// File: doc/BRIEF.md
# Triggered BCD Microsecond Delay Generator

The block turns one rising edge on an external trigger line into two timed pulses. The first is a reference pulse, which starts as soon as the synchronized edge is seen. The second is a delay pulse, which starts a programmed number of microseconds after the reference pulse. Each pulse stays high for 200 µs. The block runs from a 10 MHz clock. A prescaler restarts on every accepted trigger and divides the clock by ten, giving a 1 µs tick.

The delay is held as three decimal digits (hundreds, tens, units), so the range is 0 to 999 µs in 1 µs steps. Control logic writes the digits through a single strobe. A write only changes a holding register, and the value is copied into the down-counter when the next trigger is accepted. The counter is made of three cascaded decades, and the tick counts them down. When the count reaches zero, the delay pulse starts on that same cycle. The busy output stays high from the reference pulse until the delay pulse ends. Triggers that arrive during that time are dropped.

Top module: `bcd_delay_gen`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, `ref_o`, `dly_o` and `busy_o` are low.
- R2: A 0-to-1 transition of `trig_i` that is accepted makes `ref_o` rise on the third rising clock edge after the first edge that samples `trig_i` high (two synchronizer stages plus the start register). Holding `trig_i` high starts nothing further. A falling edge starts nothing.
- R3: `ref_o` stays high for exactly 2000 clock cycles per accepted trigger.
- R4: With a programmed value N = 100·H + 10·T + U, `dly_o` rises exactly 10·N clock cycles after `ref_o` rises. H is `wr_digits_i[11:8]`, T is `wr_digits_i[7:4]` and U is `wr_digits_i[3:0]`, each a BCD digit.
- R5: With N = 0, `dly_o` rises on the same cycle as `ref_o`.
- R6: `dly_o` stays high for exactly 2000 clock cycles.
- R7: Any written digit above 9 is stored as 9.
- R8: `busy_o` is high from the cycle `ref_o` rises until the cycle after both pulses have ended. A trigger edge that arrives while `busy_o` is high produces no reference pulse and does not change the delay in progress.
- R9: Pulsing `wr_i` for one cycle stores `wr_digits_i`. A value stored during an active cycle does not change that cycle and is used from the next accepted trigger onward.
- R10: The 10·N cycle spacing of R4 holds whatever the trigger's phase relative to any earlier tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 10 MHz system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Asynchronous external trigger |
| wr_i | input | 1 | Write strobe for the delay digits |
| wr_digits_i | input | 12 | Delay digits, BCD: hundreds [11:8], tens [7:4], units [3:0] |
| ref_o | output | 1 | Reference pulse, 2000 cycles |
| dly_o | output | 1 | Delay pulse, 2000 cycles |
| busy_o | output | 1 | High while a delay cycle or either pulse is active |

## Verification
The assertions check on every cycle that:
- each stored digit stays at or below nine;
- the down-counter never decrements from zero;
- either pulse being high implies that busy is high;
- a reference pulse never starts while busy is high;
- a zero setting starts the delay pulse together with the reference pulse.

Only the bench scenarios can show the exact 10·N spacing and the 2000-cycle widths, across several settings and idle gaps. The same holds for the dropping of a trigger that arrives in the middle of a cycle, and for a write made during a cycle taking effect on the following trigger.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  function automatic logic [DIGIT_W-1:0] clamp_digit(input logic [DIGIT_W-1:0] d);
    return (d > DIGIT_MAX) ? DIGIT_MAX : d;
  endfunction
endpackage

// File: rtl/bdg_trig_edge.sv
module bdg_trig_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], trig_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R2: an edge is a single-cycle event
  a_r2_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bdg_prescaler.sv
module bdg_prescaler #(
  parameter int unsigned DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q == LAST)        cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i & (cnt_q == LAST);

  // R10: the phase counter never leaves its range
  a_r10_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/bdg_bcd_down.sv
module bdg_bcd_down
  import bdg_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] value_i,
  input  logic                          tick_i,
  output logic                          run_o,
  output logic                          done_o
);
  logic [DIGIT_W-1:0]  dig_q   [NUM_DIGITS];
  logic [NUM_DIGITS:0] borrow;
  logic [NUM_DIGITS-1:0] is_zero;
  logic                run_q;
  logic                all_zero;
  logic                upper_zero;

  assign borrow[0] = run_q & tick_i;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
    assign is_zero[i]  = (dig_q[i] == '0);
    assign borrow[i+1] = borrow[i] & is_zero[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        dig_q[i] <= '0;
      else if (load_i)    dig_q[i] <= value_i[i*DIGIT_W +: DIGIT_W];
      else if (borrow[i]) dig_q[i] <= is_zero[i] ? DIGIT_MAX : dig_q[i] - 1'b1;
    end
  end

  assign all_zero = &is_zero;
  if (NUM_DIGITS > 1) begin : g_up
    assign upper_zero = &is_zero[NUM_DIGITS-1:1];
  end else begin : g_one
    assign upper_zero = 1'b1;
  end

  assign done_o = borrow[0] & upper_zero & (dig_q[0] == DIGIT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (load_i)  run_q <= |value_i;
    else if (done_o)  run_q <= 1'b0;
  end

  assign run_o = run_q;

  // R4: a running count never borrows past zero
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !all_zero);
endmodule

// File: rtl/bdg_pulse_timer.sv
module bdg_pulse_timer #(
  parameter int unsigned WIDTH_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(WIDTH_CYC);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= CW'(WIDTH_CYC - 1);
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse_o = act_q;

  // R3 / R6: a pulse never ends while its counter still has time left
  a_r3_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cnt_q != '0 && !start_i) |=> act_q);
endmodule

// File: rtl/bcd_delay_gen.sv
module bcd_delay_gen
  import bdg_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 10,
  parameter int unsigned NUM_DIGITS   = 3,
  parameter int unsigned PULSE_CYC    = 2000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          trig_i,
  input  logic                          wr_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] wr_digits_i,
  output logic                          ref_o,
  output logic                          dly_o,
  output logic                          busy_o
);
  localparam int unsigned VW = NUM_DIGITS * DIGIT_W;

  logic [VW-1:0] hold_q;
  logic [VW-1:0] wr_clamped;
  logic          rise, start, tick, run, done, dly_start;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_clamp
    assign wr_clamped[i*DIGIT_W +: DIGIT_W] = clamp_digit(wr_digits_i[i*DIGIT_W +: DIGIT_W]);

    // R7: stored digits are always decimal
    a_r7_digit_le9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_q[i*DIGIT_W +: DIGIT_W] <= DIGIT_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (wr_i) hold_q <= wr_clamped;
  end

  bdg_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .trig_i, .rise_o(rise)
  );

  assign start     = rise & ~busy_o;
  assign dly_start = (start & (hold_q == '0)) | done;

  bdg_prescaler #(.DIV(CLK_PER_TICK)) u_pre (
    .clk_i, .rst_ni, .clr_i(start), .en_i(run), .tick_o(tick)
  );

  bdg_bcd_down #(.NUM_DIGITS(NUM_DIGITS)) u_cnt (
    .clk_i, .rst_ni, .load_i(start), .value_i(hold_q), .tick_i(tick),
    .run_o(run), .done_o(done)
  );

  bdg_pulse_timer #(.WIDTH_CYC(PULSE_CYC)) u_ref (
    .clk_i, .rst_ni, .start_i(start), .pulse_o(ref_o)
  );

  bdg_pulse_timer #(.WIDTH_CYC(PULSE_CYC)) u_dly (
    .clk_i, .rst_ni, .start_i(dly_start), .pulse_o(dly_o)
  );

  assign busy_o = run | ref_o | dly_o;

  // R8: pulses are always covered by busy
  a_r8_busy_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o || dly_o) |-> busy_o);
  // R8: no new reference pulse while a cycle is in progress
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && busy_o) |=> !$rose(ref_o));
  // R5: a zero setting fires both pulses together
  a_r5_zero_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && hold_q == '0) |=> (ref_o && dly_o));
endmodule

// File: tb/bcd_delay_gen_bench.sv
module bcd_delay_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        wr = 1'b0;
  logic [11:0] digits = '0;
  logic        ref_p, dly_p, busy;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bcd_delay_gen u_bcd_delay_gen (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .wr_i(wr),
    .wr_digits_i(digits), .ref_o(ref_p), .dly_o(dly_p), .busy_o(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_digits(input logic [11:0] v);
    @(negedge clk); wr = 1'b1; digits = v;
    @(negedge clk); wr = 1'b0;
  endtask

  // Run one trigger and measure the pulses. mid: during the cycle, retrigger and write 003.
  task automatic fire(input int gap, input int exp_dly, input bit mid);
    int lat, t, dly_at, ref_w, dly_w, ref_rises;
    bit ref_prev;
    trig = 1'b0;
    repeat (gap) @(negedge clk);
    trig = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ref_p && lat < 20);
    check("R2 trigger to ref latency", lat, 3);
    t = 0; dly_at = -1; ref_w = 0; dly_w = 0; ref_rises = 0; ref_prev = 1'b1;
    while ((busy || ref_p) && t < 14000) begin
      if (!busy) begin end
      if (ref_p) ref_w++;
      if (dly_p) begin dly_w++; if (dly_at < 0) dly_at = t; end
      if (ref_p && !ref_prev) ref_rises++;
      ref_prev = ref_p;
      if (mid) begin
        if (t == 100) trig = 1'b0;
        if (t == 110) trig = 1'b1;
        if (t == 120) begin wr = 1'b1; digits = 12'h003; end
        if (t == 121) wr = 1'b0;
      end
      @(negedge clk); t++;
    end
    check("R4/R5/R9/R10 ref to dly spacing", dly_at, exp_dly);
    check("R3 ref width", ref_w, 2000);
    check("R6 dly width", dly_w, 2000);
    if (mid) check("R8 retrigger while busy ignored", ref_rises, 0);
    check("R8 busy low after pulses", int'(busy), 0);
    trig = 1'b0;
  endtask

  // {raw digits, expected cycles, idle gap}
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {12'h000, 16'd0,    16'd5},
    {12'h001, 16'd10,   16'd7},
    {12'h010, 16'd100,  16'd13},
    {12'h123, 16'd1230, 16'd4},
    {12'h0A5, 16'd950,  16'd9},
    {12'hF0F, 16'd9090, 16'd6},
    {12'h999, 16'd9990, 16'd11}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ref_o in reset", int'(ref_p), 0);
    check("R1 dly_o in reset", int'(dly_p), 0);
    check("R1 busy_o in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy_o after reset", int'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      write_digits(VEC[i][43:32]);   // R7 clamp covered by 0A5 and F0F rows
      fire(int'(VEC[i][15:0]), int'(VEC[i][31:16]), 1'b0);
    end

    // R8 / R9: mid-cycle retrigger dropped, mid-cycle write used next time
    write_digits(12'h050);
    fire(8, 500, 1'b1);
    fire(10, 30, 1'b0);

    // R2: falling edge and held-high level start nothing
    trig = 1'b1;
    repeat (3000) @(negedge clk);
    check("R2 held trigger no second ref", int'(ref_p), 0);
    trig = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 falling edge no ref", int'(ref_p), 0);

    // R10: odd gap phase, same setting gives same spacing
    write_digits(12'h002);
    fire(3, 20, 1'b0);
    fire(17, 20, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule